// File: doc/BRIEF.md
# Removable Card Socket Presence and Reset Controller

This block sits between a removable card socket and the host-side register logic. It synchronizes the socket's two active-low detect pins and three handshake/ready pins, and publishes their levels in a status word. It decides whether a card is seated from the two detect pins, filtering contact bounce. It also raises a one-cycle event and a sticky status flag each time the seated state changes.

A six-bit operation-mode word is held in a register. Its mode-select and card-type fields are only stored and read back. Its reset, host-enable and tristate bits drive the card reset line, the output-driver enable and a datapath reset for the rest of the controller.

While the host-enable bit is low, the block behaves as follows:
- every card-side output is held inactive;
- the datapath reset is held asserted;
- presence changes update the presence state without raising an event.

Turning host enable off and then on again therefore resets the downstream datapath.

Top module: `card_sock_ctrl`

## Requirements
- R1: `status_q` mirrors the synchronized socket pins two clock cycles after they change: bit 2 is detect pin 1, bit 3 is detect pin 2, bit 4 is input acknowledge, bit 5 is card ready and bit 6 is I/O ready. Bits 1 and 7 read zero.
- R2: `card_present` becomes 1 only when both detect pins are low, and becomes 0 when either is high. The new level is taken once the synchronized pin state has disagreed with `card_present` for `DEBOUNCE` consecutive cycles, so it changes `DEBOUNCE`+2 cycles after the pins settle.
- R3: A disagreement that lasts fewer than `DEBOUNCE` cycles leaves `card_present` unchanged and restarts the count.
- R4: While host enable is set, each change of `card_present` produces exactly one `cd_event` pulse, one cycle wide and in the cycle where `card_present` takes its new value, and sets status bit 0.
- R5: Status bit 0 stays set until `stat_clr` is high at a clock edge. If a new event arrives at that same edge, the bit stays set.
- R6: While host enable (mode bit 4) is low, presence changes raise no `cd_event` and do not set status bit 0.
- R7: `card_rst` equals mode bit 3 and `drv_en` equals the inverse of mode bit 5, both only while mode bit 4 is set. Both are 0 while host enable is clear.
- R8: `dp_rst` is high exactly while mode bit 4 is clear, so clearing and then setting host enable resets the datapath.
- R9: `mode_we` loads `mode_wdata` into the mode word at the next edge: bits 1:0 are the mode (0 memory, 1 I/O, 2 true IDE), bit 2 is the card type, bit 3 is card reset, bit 4 is host enable and bit 5 is output tristate. `mode_q` reads the word back. After reset, every output is 0, except that status bits 2 and 3 read 1 and `dp_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd1_n | input | 1 | Socket detect pin 1, low when seated |
| cd2_n | input | 1 | Socket detect pin 2, low when seated |
| in_ack | input | 1 | Input acknowledge pin |
| card_rdy | input | 1 | Card ready pin |
| io_rdy | input | 1 | I/O ready pin |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word write value |
| stat_clr | input | 1 | Clears the sticky status-change bit |
| status_q | output | 8 | Status word |
| mode_q | output | 6 | Mode word read-back |
| card_present | output | 1 | Filtered card-seated state |
| cd_event | output | 1 | One-cycle presence-change event |
| card_rst | output | 1 | Card reset line |
| drv_en | output | 1 | Card-side output driver enable |
| dp_rst | output | 1 | Datapath reset for the controller |

## Verification
The results fall due at three different latencies:
- status pin bits follow a pin change after exactly two cycles;
- `card_present`, `cd_event` and status bit 0 follow a settled detect-pin change after `DEBOUNCE`+2 cycles;
- the mode word and the gated outputs follow a write after one cycle.

A behavioural model in the bench applies the same latencies. It uses a two-deep queue for the pin synchronizer and an integer count for the filter. It compares every output on each falling clock edge, so every cycle of each window is checked, not only the final one.

Stimulus covers several cases:
- bounce glitches shorter than the filter;
- one-pin removal;
- a clear request held across an event;
- presence changes while host enable is off.

// File: rtl/card_sock_pkg.sv
package card_sock_pkg;

  typedef struct packed {
    logic       tristate;
    logic       host_en;
    logic       card_rst;
    logic       card_type;
    logic [1:0] sel;
  } mode_t;

  localparam int MODE_W   = 6;
  localparam int PINS_W   = 5;
  localparam int PIN_CD1  = 0;
  localparam int PIN_CD2  = 1;
  localparam int PIN_ACK  = 2;
  localparam int PIN_RDY  = 3;
  localparam int PIN_IORD = 4;

  localparam logic [PINS_W-1:0] PINS_RST = 5'b00011;

endpackage

// File: rtl/card_sock_sync.sv
module card_sock_sync #(
  parameter int                W       = 5,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= pin_i[i];
        s2 <= s1;
      end
    end
    assign pin_o[i] = s2;
  end

endmodule

// File: rtl/card_sock_debounce.sv
module card_sock_debounce #(
  parameter int DEBOUNCE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic state_o,
  output logic flip_o
);

  localparam int CW = (DEBOUNCE > 2) ? $clog2(DEBOUNCE) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

  logic [CW-1:0] cnt;
  logic          state_q;
  logic          differ;

  assign differ  = raw_i != state_q;
  assign flip_o  = differ && (cnt == LAST);
  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      state_q <= 1'b0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      state_q <= raw_i;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a new state always equals the input level that was being counted
  assert_takes_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> (state_q == $past(raw_i)));

  // R3: a disagreement that ends restarts the count
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(differ) |-> (cnt == '0));

  initial assert (DEBOUNCE >= 2);

endmodule

// File: rtl/card_sock_mode.sv
module card_sock_mode
  import card_sock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output mode_t             mode_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_o <= '0;
    else if (we_i) mode_o <= mode_t'(wdata_i);
  end

  // R9: the word changes only through a write
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_i) |-> $stable(mode_o));

endmodule

// File: rtl/card_sock_ctrl.sv
module card_sock_ctrl
  import card_sock_pkg::*;
#(
  parameter int DEBOUNCE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cd1_n,
  input  logic              cd2_n,
  input  logic              in_ack,
  input  logic              card_rdy,
  input  logic              io_rdy,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              stat_clr,
  output logic [7:0]        status_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              card_present,
  output logic              cd_event,
  output logic              card_rst,
  output logic              drv_en,
  output logic              dp_rst
);

  logic [PINS_W-1:0] pins_raw, pins_s;
  mode_t             mode;
  logic              seated_raw, flip, chg_q, evt_q;

  assign pins_raw = {io_rdy, card_rdy, in_ack, cd2_n, cd1_n};

  card_sock_sync #(.W(PINS_W), .RST_VAL(PINS_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_raw),
    .pin_o (pins_s)
  );

  assign seated_raw = !pins_s[PIN_CD1] && !pins_s[PIN_CD2];

  card_sock_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (seated_raw),
    .state_o (card_present),
    .flip_o  (flip)
  );

  card_sock_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mode_we),
    .wdata_i (mode_wdata),
    .mode_o  (mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      evt_q <= flip && mode.host_en;
      if (flip && mode.host_en) chg_q <= 1'b1;
      else if (stat_clr)        chg_q <= 1'b0;
    end
  end

  assign cd_event = evt_q;
  assign mode_q   = mode;
  assign status_q = {1'b0, pins_s[PIN_IORD], pins_s[PIN_RDY], pins_s[PIN_ACK],
                     pins_s[PIN_CD2], pins_s[PIN_CD1], 1'b0, chg_q};
  assign card_rst = mode.host_en && mode.card_rst;
  assign drv_en   = mode.host_en && !mode.tristate;
  assign dp_rst   = !mode.host_en;

  // R4: an event is never longer than one cycle
  assert_evt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cd_event |=> !cd_event);

  // R4: an enabled presence change is always announced
  assert_change_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((card_present != $past(card_present)) && $past(mode.host_en)) |-> cd_event);

  // R6: no event without host enable in the cycle it was decided
  assert_evt_needs_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cd_event |-> $past(mode.host_en));

  // R5: the change flag only drops on a clear request
  assert_chg_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chg_q) && !$past(stat_clr)) |-> chg_q);

  // R7: disabled host keeps the card out of reset and drivers off
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |-> (!card_rst && !drv_en));

endmodule

// File: tb/card_sock_ctrl_bench.sv
module card_sock_ctrl_bench;

  localparam int DEB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cd1_n = 1'b1, cd2_n = 1'b1, in_ack = 1'b0, card_rdy = 1'b0, io_rdy = 1'b0;
  logic       mode_we = 1'b0, stat_clr = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic [7:0] status_q;
  logic [5:0] mode_q;
  logic       card_present, cd_event, card_rst, drv_en, dp_rst;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_sock_ctrl #(.DEBOUNCE(DEB)) u_card_sock_ctrl (
    .clk, .rst_n, .cd1_n, .cd2_n, .in_ack, .card_rdy, .io_rdy,
    .mode_we, .mode_wdata, .stat_clr, .status_q, .mode_q,
    .card_present, .cd_event, .card_rst, .drv_en, .dp_rst
  );

  // behavioural reference
  logic [4:0] dq[$];
  logic       m_pres, m_evt, m_chg;
  logic [5:0] m_mode;
  int         m_cnt;

  initial begin
    dq = '{5'b00011, 5'b00011};
    m_pres = 0; m_evt = 0; m_chg = 0; m_mode = 0; m_cnt = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      dq = '{5'b00011, 5'b00011};
      m_pres = 0; m_evt = 0; m_chg = 0; m_mode = 0; m_cnt = 0;
    end else begin
      logic seat, ev;
      seat = (dq[0][0] == 1'b0) && (dq[0][1] == 1'b0);
      ev = 0;
      if (seat != m_pres) begin
        if (m_cnt == DEB - 1) begin
          m_pres = seat; m_cnt = 0; ev = m_mode[4];
        end else m_cnt++;
      end else m_cnt = 0;
      m_evt = ev;
      if (ev) m_chg = 1;
      else if (stat_clr) m_chg = 0;
      if (mode_we) m_mode = mode_wdata;
      dq.push_back({io_rdy, card_rdy, in_ack, cd2_n, cd1_n});
      void'(dq.pop_front());
    end
  end

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      logic [7:0] es;
      logic [2:0] eo, ao;
      es = {1'b0, dq[0][4], dq[0][3], dq[0][2], dq[0][1], dq[0][0], 1'b0, m_chg};
      chk(status_q == es, "R1/R5 status", status_q, es);
      chk(card_present == m_pres, "R2/R3 presence", {7'b0, card_present}, {7'b0, m_pres});
      chk(cd_event == m_evt, "R4/R6 event", {7'b0, cd_event}, {7'b0, m_evt});
      eo = {m_mode[4] & m_mode[3], m_mode[4] & ~m_mode[5], ~m_mode[4]};
      ao = {card_rst, drv_en, dp_rst};
      chk(ao == eo, "R7/R8 gated outputs", {5'b0, ao}, {5'b0, eo});
      chk(mode_q == m_mode, "R9 mode word", {2'b0, mode_q}, {2'b0, m_mode});
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(logic [5:0] v);
    mode_we = 1; mode_wdata = v; step(1); mode_we = 0;
  endtask

  initial begin
    step(3);
    // R9 reset state: checks start right after release
    rst_n = 1;
    step(5);
    wr_mode(6'b010010);                 // host enable, true IDE
    step(3);
    cd1_n = 0; step(4); cd2_n = 0;      // R2 insertion, one pin at a time
    step(DEB + 8);
    in_ack = 1; step(3); card_rdy = 1; step(2); io_rdy = 1; step(3);  // R1
    in_ack = 0; io_rdy = 0; step(4);
    cd1_n = 1; step(5); cd1_n = 0;      // R3 glitch shorter than filter
    step(DEB + 6);
    cd2_n = 1; step(DEB - 3); cd2_n = 0; // R3 near-threshold glitch
    step(DEB + 6);
    stat_clr = 1; step(1); stat_clr = 0; step(3);  // R5 clear
    stat_clr = 1; cd2_n = 1;            // R5 clear held across an event
    step(DEB + 6);
    stat_clr = 0; step(3);
    wr_mode(6'b111110); step(4);        // R7 reset + tristate
    wr_mode(6'b011001); step(4);        // R7 reset, drivers on
    wr_mode(6'b001101); step(3);        // R8 host off, R7 gated
    cd2_n = 0; step(DEB + 8);           // R6 insertion silent
    cd1_n = 1; step(DEB + 8);           // R6 removal silent
    cd1_n = 0; step(DEB + 8);
    wr_mode(6'b010000); step(4);        // R8 re-enable
    cd1_n = 1; cd2_n = 1; step(DEB + 8); // R4 removal with host on
    for (int i = 0; i < 6; i++) begin   // R2/R3 mixed bounce
      cd1_n = i[0]; cd2_n = i[1]; step(3 + 7 * i);
    end
    cd1_n = 0; cd2_n = 0; step(DEB + 8);
    step(5);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule